// File: doc/BRIEF.md
# Cyclic Audio Buffer Descriptor Generator

This engine turns one transfer setup into the list of buffer descriptor entries that a DMA channel walks through a cyclic audio buffer. The buffer is treated as one contiguous region. It starts at a 64-bit base address and spans a given number of bytes. The buffer is divided into periods of a programmed size. Each period is cut into one or more entries, and a cut may also fall on a 4 KiB page boundary when page alignment is enabled. Each entry carries an address, a byte length and an interrupt-on-completion (IOC) flag. The engine hands the entries out one per cycle over a valid/ready write port.

Software supplies the setup and pulses start. The engine then streams entries until the whole buffer is described. It then raises done and presents the entry count, the index of the last valid entry and the final byte offset reached. A parameter caps the list length. A setup that needs more entries than the cap stops at the cap and reports an error.

Top module: `bufdesc_gen`

## Requirements
- R1: After reset the engine is idle: entValid, busy, done and overflowErr are 0, and entCount is 0.
- R2: A start pulse in the idle or done state captures baseAddr, bufSize, periodSize, alignEn and iocEn, and busy rises at the next edge. A start pulse or any change on the setup inputs while busy has no effect on the list being produced.
- R3: A periodSize of 0 makes the whole buffer a single period.
- R4: The buffer is cut into consecutive periods of periodSize bytes. If the buffer size is not a multiple of the period size, the remaining bytes form one shorter final period. No entry spans two periods.
- R5: With alignEn = 1, an entry at buffer offset `off` is no longer than 0x1000 - (off & 0xFFF), so no entry crosses a 4 KiB boundary of the offset. With alignEn = 0, an entry covers the rest of its period.
- R6: entIoc is 1 only on the entry that finishes a full-length period, and only when iocEn = 1. Every other entry of that period has entIoc = 0.
- R7: Every entry of the short final period has entIoc = 0, whatever iocEn says.
- R8: At most MAX_ENTRIES entries are produced. When one more entry is needed, the engine stops, sets overflowErr and enters done. overflowErr stays set until the next accepted start.
- R9: lastIndex equals entCount - 1, modulo 2^CNT_W. A count of 0 therefore gives all ones.
- R10: The entry address is baseAddr plus the entry's byte offset in the buffer. The low 32 bits appear on entAddrLo and the high 32 bits on entAddrHi.
- R11: When generation completes without error, done is 1 and finalOffset equals bufSize. done stays 1 until the next accepted start.
- R12: While entValid = 1 and entReady = 0, the entry fields hold steady. Each cycle with entValid and entReady both 1 consumes one entry, so the port can move one entry per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin generation with the current setup |
| baseAddr | input | ADDR_W (64) | Buffer base address |
| bufSize | input | LEN_W (32) | Buffer size in bytes |
| periodSize | input | LEN_W (32) | Period size in bytes; 0 means the whole buffer |
| alignEn | input | 1 | Split entries at 4 KiB offset boundaries |
| iocEn | input | 1 | Allow IOC on entries that end a full period |
| entValid | output | 1 | Entry fields are valid |
| entReady | input | 1 | Consumer accepts the entry |
| entAddrLo | output | 32 | Entry address, low word |
| entAddrHi | output | 32 | Entry address, high word |
| entLen | output | LEN_W (32) | Entry length in bytes |
| entIoc | output | 1 | Interrupt-on-completion flag |
| busy | output | 1 | Generation in progress |
| done | output | 1 | Generation finished; held until next start |
| entCount | output | CNT_W (9) | Number of entries produced |
| lastIndex | output | CNT_W (9) | entCount - 1 |
| finalOffset | output | LEN_W (32) | Byte offset reached |
| overflowErr | output | 1 | Entry cap was hit |

## Verification
A start pulse captured at one rising edge makes busy and the first entry visible after that edge, so the first entry can be read in the following low phase. An entry accepted at an edge is replaced by the next entry right after that edge. After the last acceptance, the engine spends one cycle noticing that the buffer is finished, and done, finalOffset, entCount and lastIndex settle at the edge after that. The bench drives inputs and samples outputs only at falling edges. It waits for done, with a cycle limit, before reading the summary outputs. When it holds entReady low, it compares the entry fields across consecutive falling edges.

// File: rtl/bufdesc_pkg.sv
package bufdesc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } genState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture setup and clear walking state
    logic fire;     // current entry accepted, advance
    logic finish;   // list complete (or aborted)
    logic flagErr;  // entry cap hit
  } dpStrobe_t;

endpackage

// File: rtl/bufdesc_ctrl.sv
module bufdesc_ctrl
  import bufdesc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       allDone,
  input  logic       atLimit,
  input  logic       entReady,
  output dpStrobe_t  strobe,
  output logic       entValid,
  output logic       busy,
  output logic       done
);

  genState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    entValid  = 1'b0;
    case (state)
      ST_RUN: begin
        if (allDone) begin
          strobe.finish = 1'b1;
          stateNext     = ST_DONE;
        end else if (atLimit) begin
          strobe.flagErr = 1'b1;
          strobe.finish  = 1'b1;
          stateNext      = ST_DONE;
        end else begin
          entValid    = 1'b1;
          strobe.fire = entReady;
        end
      end
      default: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          stateNext   = ST_RUN;
        end
      end
    endcase
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/bufdesc_dpath.sv
module bufdesc_dpath
  import bufdesc_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int MAX_ENTRIES = 256,
  parameter int PAGE_BYTES  = 4096,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int PAGE_W     = $clog2(PAGE_BYTES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LEN_W-1:0]  bufSize,
  input  logic [LEN_W-1:0]  periodSize,
  input  logic              alignEn,
  input  logic              iocEn,
  output logic              allDone,
  output logic              atLimit,
  output logic [ADDR_W-1:0] entAddr,
  output logic [LEN_W-1:0]  entLen,
  output logic              entIoc,
  output logic [CNT_W-1:0]  entCount,
  output logic [LEN_W-1:0]  curOffset,
  output logic              errFlag
);

  logic [ADDR_W-1:0] baseR;
  logic [LEN_W-1:0]  sizeR, effR, offR, leftR;
  logic              alignR, iocR, shortR;
  logic [CNT_W-1:0]  cntR;
  logic              errR;

  logic [LEN_W-1:0]  restBytes, curLeft, pageRoom, chunk;
  logic              newPeriod, curShort;

  // Period bookkeeping: a fresh period is opened on the fly when the last
  // one is used up, so no cycle is lost between periods.
  always_comb begin
    restBytes = sizeR - offR;
    newPeriod = (leftR == '0);
    curShort  = newPeriod ? (restBytes < effR) : shortR;
    if (newPeriod) curLeft = (restBytes < effR) ? restBytes : effR;
    else           curLeft = leftR;
    pageRoom  = LEN_W'(PAGE_BYTES) - LEN_W'(offR[PAGE_W-1:0]);
    chunk     = (alignR && (pageRoom < curLeft)) ? pageRoom : curLeft;
  end

  assign entLen    = chunk;
  assign entIoc    = iocR && !curShort && (chunk == curLeft);
  assign entAddr   = baseR + ADDR_W'(offR);
  assign allDone   = newPeriod && (offR == sizeR);
  assign atLimit   = (cntR == CNT_W'(MAX_ENTRIES));
  assign entCount  = cntR;
  assign curOffset = offR;
  assign errFlag   = errR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR  <= '0;
      sizeR  <= '0;
      effR   <= '0;
      offR   <= '0;
      leftR  <= '0;
      alignR <= 1'b0;
      iocR   <= 1'b0;
      shortR <= 1'b0;
      cntR   <= '0;
      errR   <= 1'b0;
    end else if (strobe.load) begin
      baseR  <= baseAddr;
      sizeR  <= bufSize;
      effR   <= (periodSize == '0) ? bufSize : periodSize;
      alignR <= alignEn;
      iocR   <= iocEn;
      offR   <= '0;
      leftR  <= '0;
      shortR <= 1'b0;
      cntR   <= '0;
      errR   <= 1'b0;
    end else begin
      if (strobe.fire) begin
        offR   <= offR + chunk;
        leftR  <= curLeft - chunk;
        shortR <= curShort;
        cntR   <= cntR + CNT_W'(1);
      end
      if (strobe.flagErr) errR <= 1'b1;
    end
  end

endmodule

// File: rtl/bufdesc_gen.sv
module bufdesc_gen
  import bufdesc_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int MAX_ENTRIES = 256,
  parameter int PAGE_BYTES  = 4096,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LEN_W-1:0]  bufSize,
  input  logic [LEN_W-1:0]  periodSize,
  input  logic              alignEn,
  input  logic              iocEn,
  output logic              entValid,
  input  logic              entReady,
  output logic [31:0]       entAddrLo,
  output logic [31:0]       entAddrHi,
  output logic [LEN_W-1:0]  entLen,
  output logic              entIoc,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  entCount,
  output logic [CNT_W-1:0]  lastIndex,
  output logic [LEN_W-1:0]  finalOffset,
  output logic              overflowErr
);

  dpStrobe_t         strobe;
  logic              allDone, atLimit;
  logic [ADDR_W-1:0] entAddr;

  bufdesc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .allDone    (allDone),
    .atLimit    (atLimit),
    .entReady   (entReady),
    .strobe     (strobe),
    .entValid   (entValid),
    .busy       (busy),
    .done       (done)
  );

  bufdesc_dpath #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .MAX_ENTRIES (MAX_ENTRIES),
    .PAGE_BYTES  (PAGE_BYTES)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseAddr   (baseAddr),
    .bufSize    (bufSize),
    .periodSize (periodSize),
    .alignEn    (alignEn),
    .iocEn      (iocEn),
    .allDone    (allDone),
    .atLimit    (atLimit),
    .entAddr    (entAddr),
    .entLen     (entLen),
    .entIoc     (entIoc),
    .entCount   (entCount),
    .curOffset  (finalOffset),
    .errFlag    (overflowErr)
  );

  // Address word split; narrow address spaces leave the high word zero
  assign entAddrLo = entAddr[31:0];
  generate
    if (ADDR_W > 32) begin : g_hiWord
      assign entAddrHi = 32'(entAddr[ADDR_W-1:32]);
    end else begin : g_noHiWord
      assign entAddrHi = '0;
    end
  endgenerate

  assign lastIndex = entCount - CNT_W'(1);

endmodule

// File: rtl/bufdesc_gen_chk.sv
module bufdesc_gen_chk #(
  parameter int ADDR_W      = 64,
  parameter int LEN_W       = 32,
  parameter int MAX_ENTRIES = 256,
  parameter int PAGE_BYTES  = 4096,
  localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int PAGE_W     = $clog2(PAGE_BYTES),
  localparam int SUM_W      = LEN_W + 1
)(
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [LEN_W-1:0]  bufSize,
  input logic              alignEn,
  input logic              busy,
  input logic              done,
  input logic              entValid,
  input logic              entReady,
  input logic [31:0]       entAddrLo,
  input logic [31:0]       entAddrHi,
  input logic [LEN_W-1:0]  entLen,
  input logic              entIoc,
  input logic [CNT_W-1:0]  entCount,
  input logic [LEN_W-1:0]  finalOffset,
  input logic              overflowErr
);

  logic [ADDR_W-1:0] baseL;
  logic [LEN_W-1:0]  sizeL, runOff;
  logic              alignL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseL  <= '0;
      sizeL  <= '0;
      runOff <= '0;
      alignL <= 1'b0;
    end else if (startPulse && !busy) begin
      baseL  <= baseAddr;
      sizeL  <= bufSize;
      alignL <= alignEn;
      runOff <= '0;
    end else if (entValid && entReady) begin
      runOff <= runOff + entLen;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!entValid && !busy));

  assert_page_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (entValid && alignL) |->
      ((SUM_W'(runOff[PAGE_W-1:0]) + SUM_W'(entLen)) <= SUM_W'(PAGE_BYTES)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    entCount <= CNT_W'(MAX_ENTRIES));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (entValid && entReady) |=> (entCount == $past(entCount) + CNT_W'(1)));

  assert_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    entValid |-> ({entAddrHi, entAddrLo} == 64'(baseL + ADDR_W'(runOff))));

  assert_final_offset_R11: assert property (@(posedge clk) disable iff (!rstN)
    (done && !overflowErr) |-> (finalOffset == sizeL));

  assert_hold_entry_R12: assert property (@(posedge clk) disable iff (!rstN)
    (entValid && !entReady) |=>
      (entValid && $stable(entAddrLo) && $stable(entAddrHi) &&
       $stable(entLen) && $stable(entIoc)));

  assert_nonzero_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    entValid |-> (entLen != '0));

endmodule

bind bufdesc_gen bufdesc_gen_chk #(
  .ADDR_W      (ADDR_W),
  .LEN_W       (LEN_W),
  .MAX_ENTRIES (MAX_ENTRIES),
  .PAGE_BYTES  (PAGE_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .baseAddr    (baseAddr),
  .bufSize     (bufSize),
  .alignEn     (alignEn),
  .busy        (busy),
  .done        (done),
  .entValid    (entValid),
  .entReady    (entReady),
  .entAddrLo   (entAddrLo),
  .entAddrHi   (entAddrHi),
  .entLen      (entLen),
  .entIoc      (entIoc),
  .entCount    (entCount),
  .finalOffset (finalOffset),
  .overflowErr (overflowErr)
);

// File: tb/bufdesc_gen_bench.sv
module bufdesc_gen_bench;

  localparam int CNT_W = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [63:0] baseAddr = '0;
  logic [31:0] bufSize = '0;
  logic [31:0] periodSize = '0;
  logic        alignEn = 1'b0;
  logic        iocEn = 1'b0;
  logic        entReady = 1'b0;
  logic        entValid, entIoc, busy, done, overflowErr;
  logic [31:0] entAddrLo, entAddrHi, entLen, finalOffset;
  logic [CNT_W-1:0] entCount, lastIndex;

  int total = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bufdesc_gen u_bufdesc_gen (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .baseAddr(baseAddr),
    .bufSize(bufSize), .periodSize(periodSize), .alignEn(alignEn),
    .iocEn(iocEn), .entValid(entValid), .entReady(entReady),
    .entAddrLo(entAddrLo), .entAddrHi(entAddrHi), .entLen(entLen),
    .entIoc(entIoc), .busy(busy), .done(done), .entCount(entCount),
    .lastIndex(lastIndex), .finalOffset(finalOffset),
    .overflowErr(overflowErr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total = total + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stimulus table: setup and expected entry count / IOC count
  localparam int NV = 8;
  localparam logic [63:0] vBase [NV] = '{64'h1_0000_0000, 64'h0000_2000, 64'hABCD_0000_1000,
                                         64'h40, 64'h7_0000_0000, 64'h100, 64'h0, 64'hFFFF_F000};
  localparam logic [31:0] vSize [NV] = '{32'h3000, 32'h2800, 32'h2400, 32'h2400,
                                         32'h3000, 32'h1000, 32'h100, 32'h1000};
  localparam logic [31:0] vPer  [NV] = '{32'h1000, 32'h1000, 32'h0, 32'h0,
                                         32'h1800, 32'h300, 32'h200, 32'h400};
  localparam bit vAlign [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam bit vIoc   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int vCnt   [NV] = '{3, 3, 3, 1, 4, 6, 1, 4};
  localparam int vIocN  [NV] = '{3, 2, 1, 1, 2, 0, 0, 4};

  // Run one generation; mode 0 = always ready, 1 = ready 2 of 3 cycles.
  // glitch: pulse start with other setup while busy.
  task automatic runGen(input logic [63:0] b, input logic [31:0] s, input logic [31:0] p,
                        input logic a, input logic i, input int mode, input bit glitch,
                        output int nEnt, output int nIoc, output int nBad);
    logic [31:0] mOff, mLeft, eff, rest, ch, room;
    logic        mShort, eIoc, held;
    logic [31:0] hLo, hHi, hLen;
    logic        hIoc;
    nEnt = 0; nIoc = 0; nBad = 0;
    mOff = 0; mLeft = 0; mShort = 1'b0; held = 1'b0;
    hLo = 0; hHi = 0; hLen = 0; hIoc = 1'b0;
    eff = (p == 0) ? s : p;
    @(negedge clk);
    baseAddr = b; bufSize = s; periodSize = p; alignEn = a; iocEn = i;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int c = 0; c < 5000 && !done; c++) begin
      if (glitch && c == 2) begin
        startPulse = 1'b1; bufSize = 32'h40; baseAddr = '0; periodSize = 32'h10;
      end else begin
        startPulse = 1'b0;
      end
      entReady = (mode == 0) ? 1'b1 : ((c % 3) != 0);
      #1;
      if (held) begin
        if (!entValid || entAddrLo != hLo || entAddrHi != hHi ||
            entLen != hLen || entIoc != hIoc) nBad++;
        held = 1'b0;
      end
      if (entValid && !entReady) begin
        held = 1'b1; hLo = entAddrLo; hHi = entAddrHi; hLen = entLen; hIoc = entIoc;
      end
      if (entValid && entReady) begin
        if (mLeft == 0) begin
          rest = s - mOff;
          mShort = rest < eff;
          mLeft = mShort ? rest : eff;
        end
        ch = mLeft;
        room = 32'h1000 - (mOff & 32'hFFF);
        if (a && room < ch) ch = room;
        eIoc = i && !mShort && (ch == mLeft);
        if (entLen != ch || {entAddrHi, entAddrLo} != b + 64'(mOff) || entIoc != eIoc) begin
          nBad++;
          $display("entry %0d: len %0h/%0h ioc %0b/%0b", nEnt, entLen, ch, entIoc, eIoc);
        end
        if (entIoc) nIoc++;
        mOff = mOff + ch;
        mLeft = mLeft - ch;
        nEnt++;
      end
      @(negedge clk);
    end
    startPulse = 1'b0;
    entReady = 1'b0;
  endtask

  initial begin
    int n, ni, nb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 entValid", entValid, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 overflowErr", overflowErr, 0);
    chk("R1 entCount", entCount, 0);
    rstN = 1'b1;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      runGen(vBase[v], vSize[v], vPer[v], vAlign[v], vIoc[v], v % 2, 1'b0, n, ni, nb);
      chk("R4,R5,R6,R7,R10,R12 entry fields", nb, 0);
      chk("R3,R4,R5 entry count", n, vCnt[v]);
      chk("R6,R7 ioc count", ni, vIocN[v]);
      chk("R11 done", done, 1);
      chk("R11 finalOffset", finalOffset, vSize[v]);
      chk("R9 lastIndex", lastIndex, CNT_W'(vCnt[v] - 1));
      chk("R8 no error", overflowErr, 0);
    end

    // R11: done held
    repeat (3) @(negedge clk);
    chk("R11 done held", done, 1);

    // R2: start while busy ignored (2 entries of 0x1000, ioc on both)
    runGen(64'h5000, 32'h2000, 32'h1000, 1'b0, 1'b1, 1, 1'b1, n, ni, nb);
    chk("R2 entries unchanged", nb, 0);
    chk("R2 count", n, 2);
    chk("R2 finalOffset", finalOffset, 32'h2000);

    // Zero-size buffer
    runGen(64'h0, 32'h0, 32'h100, 1'b1, 1'b1, 0, 1'b0, n, ni, nb);
    chk("R9 zero count", entCount, 0);
    chk("R9 zero lastIndex", lastIndex, 9'h1FF);
    chk("R11 zero done", done, 1);

    // R8 overflow: 2000 bytes in 4-byte periods needs 500 entries
    runGen(64'h8000, 32'd2000, 32'd4, 1'b0, 1'b1, 0, 1'b0, n, ni, nb);
    chk("R8 entries", nb, 0);
    chk("R8 count", n, 256);
    chk("R8 error", overflowErr, 1);
    chk("R8 done", done, 1);
    chk("R8 finalOffset", finalOffset, 32'd1024);
    chk("R8 lastIndex", lastIndex, 255);
    repeat (4) @(negedge clk);
    chk("R8 error held", overflowErr, 1);
    @(negedge clk);
    startPulse = 1'b1; bufSize = 32'h10; periodSize = 32'h10;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R8 error cleared", overflowErr, 0);
    chk("R2 busy after start", busy, 1);
    entReady = 1'b1;
    repeat (3) @(negedge clk);
    entReady = 1'b0;
    chk("R11 short run done", done, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule